// File: doc/BRIEF.md
# Expansion Slot Configuration Access and Channel-Check Scanner

This block gives a host controlled access to the per-slot configuration banks of an eight-slot expansion bus. Each slot owns a bank of eight byte-wide configuration registers. The host reaches a bank through a small register window. First it writes all ones to the board-setup register, which turns board setup off. Then it writes a slot number together with an enable bit to the slot-select register. While both conditions hold, reads and writes in the configuration window go to the selected slot's bank. Otherwise the window is closed. Writing zero to the slot-select register deselects the slot again.

On request, a hardware scanner visits every slot in order, one per clock. It reads each slot's check register, in which a cleared bit means an error. It reports a mask of all slots that raised a channel check and the one-based number of the lowest such slot. When that slot shows that extended status is present, it also returns the slot's two extended status bytes. When no slot is checking, the scanner flags the event as a non-slot error so that system logic can handle it elsewhere. The banks are modelled inside the block as register arrays.

Top module: `slot_cfg_scan`

## Requirements
- R1: After reset, the board-setup register reads 0xFF and the slot-select register reads 0x00. Every bank register holds 0xFF. scan_busy, scan_done, nonslot_err, ext_valid, chk_mask, chk_first_slot, ext_pos6 and ext_pos7 are all zero.
- R2: The host port uses these select codes: host_sel 0 is board setup, 1 is slot select, 2 is the configuration window and 3 is unmapped. An unmapped read returns 0xFF. The slot-select register keeps only the slot number in bits 2:0 and the enable in bit 3. Higher bits are discarded and read back as zero.
- R3: When the enable bit is set and board setup reads 0xFF, a window write with host_reg = r stores the data in register r of the selected slot. A window read returns that byte. Other slots are not affected.
- R4: When the enable bit is clear, window reads return 0xFF and window writes leave every bank unchanged.
- R5: When board setup holds any value other than 0xFF, window reads return 0xFF and window writes are ignored, even if the enable bit is set.
- R6: A scan_start sampled while idle raises scan_busy for eight cycles, one per slot. scan_done then pulses for one cycle in the same cycle that scan_busy falls, which is the eighth cycle after the start edge.
- R7: When scan_done pulses, bit i of chk_mask is set exactly when bit 7 of register 5 in slot i is 0. The scan results hold their values until the next scan_done.
- R8: chk_first_slot equals the index of the lowest checking slot plus one, or 0 if no slot is checking. ext_valid is set when bit 6 of that slot's register 5 is 0. In that case ext_pos6 and ext_pos7 carry that slot's registers 6 and 7; otherwise both are zero.
- R9: nonslot_err pulses together with scan_done exactly when no slot is checking.
- R10: A scan forces board setup to 0xFF when it starts and clears the slot-select register when it finishes.
- R11: While scan_busy is high, host writes to any register are ignored and a further scan_start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Host target: 0 board setup, 1 slot select, 2 window, 3 unmapped |
| host_reg | input | 3 | Register index inside the configuration window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| scan_start | input | 1 | Start a channel-check scan |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle pulse when a scan completes |
| chk_mask | output | 8 | Slots with channel check asserted |
| chk_first_slot | output | 4 | One-based number of the lowest checking slot, 0 if none |
| ext_valid | output | 1 | Extended status present for the lowest checking slot |
| ext_pos6 | output | 8 | Register 6 of the lowest checking slot |
| ext_pos7 | output | 8 | Register 7 of the lowest checking slot |
| nonslot_err | output | 1 | Pulse with scan_done when no slot is checking |

## Verification
The assertions assume that host_sel is only driven with the four defined codes. They also assume that scan_start and host writes arrive as single synchronous strobes, and that the host reads the slot-select register only through host_sel 1. The stimulus applies every strobe for exactly one cycle between falling edges. It issues a further start and a slot-select write during a running scan to exercise R11. It fills register 5 of every slot with random patterns, biased so that channel checks and extended-status flags occur both alone and together, so that R7 to R9 are covered in every combination.

// File: rtl/slot_cfg_pkg.sv
package slot_cfg_pkg;
  typedef enum logic [1:0] {
    SEL_BOARD = 2'd0,
    SEL_SLOT  = 2'd1,
    SEL_WIN   = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  // register indices inside a slot bank
  localparam int CHK_REG   = 5;
  localparam int EXT_REG_A = 6;
  localparam int EXT_REG_B = 7;
  // bit positions inside the check register (both active low)
  localparam int CHK_BIT   = 7;
  localparam int STAT_BIT  = 6;
endpackage

// File: rtl/slot_cfg_setup.sv
module slot_cfg_setup #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_board,
  input  logic          wr_slot,
  input  logic [DW-1:0] wdata,
  input  logic          force_off,
  input  logic          clear_slot,
  output logic [DW-1:0] board_q,
  output logic [AW-1:0] slot_q
);
  logic [DW-1:0] board_d;
  logic [AW-1:0] slot_d;

  always_comb begin
    board_d = board_q;
    if (force_off)     board_d = '1;
    else if (wr_board) board_d = wdata;
  end

  always_comb begin
    slot_d = slot_q;
    if (clear_slot)   slot_d = '0;
    else if (wr_slot) slot_d = wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      board_q <= '1;
      slot_q  <= '0;
    end else begin
      board_q <= board_d;
      slot_q  <= slot_d;
    end
  end
endmodule

// File: rtl/slot_cfg_bank.sv
module slot_cfg_bank
  import slot_cfg_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int REGS  = 8,
  parameter int DW    = 8,
  localparam int SW   = $clog2(SLOTS),
  localparam int RW   = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wslot,
  input  logic [RW-1:0] wreg,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rslot,
  input  logic [RW-1:0] rreg,
  output logic [DW-1:0] rdata,
  input  logic [SW-1:0] sslot,
  output logic [DW-1:0] s_chk,
  output logic [DW-1:0] s_ext_a,
  output logic [DW-1:0] s_ext_b
);
  logic [REGS-1:0][DW-1:0] mem_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_row
    logic [REGS-1:0][DW-1:0] row_d;
    logic                    row_en;

    assign row_en = we && (wslot == SW'(g));

    always_comb begin
      row_d = mem_q[g];
      row_d[wreg] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= '1;
      else if (row_en) mem_q[g] <= row_d;
    end
  end

  assign rdata   = mem_q[rslot][rreg];
  assign s_chk   = mem_q[sslot][CHK_REG];
  assign s_ext_a = mem_q[sslot][EXT_REG_A];
  assign s_ext_b = mem_q[sslot][EXT_REG_B];
endmodule

// File: rtl/slot_cfg_scanner.sv
module slot_cfg_scanner
  import slot_cfg_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int DW    = 8,
  localparam int SW   = $clog2(SLOTS),
  localparam int NW   = SW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    chk_byte,
  input  logic [DW-1:0]    ext_a,
  input  logic [DW-1:0]    ext_b,
  output logic [SW-1:0]    cur_slot,
  output logic             begin_p,
  output logic             end_p,
  output logic             busy,
  output logic             done,
  output logic [SLOTS-1:0] mask,
  output logic [NW-1:0]    first_slot,
  output logic             ev,
  output logic [DW-1:0]    e6,
  output logic [DW-1:0]    e7,
  output logic             nonslot
);
  // working state
  logic             busy_q, busy_d;
  logic [SW-1:0]    idx_q, idx_d;
  logic [SLOTS-1:0] wmask_q, wmask_d;
  logic             wfound_q, wfound_d;
  logic [NW-1:0]    wfirst_q, wfirst_d;
  logic             wev_q, wev_d;
  logic [DW-1:0]    w6_q, w6_d, w7_q, w7_d;
  // committed results
  logic             done_d, nonslot_d, commit;
  logic [SLOTS-1:0] mask_q;
  logic [NW-1:0]    first_q;
  logic             ev_q;
  logic [DW-1:0]    e6_q, e7_q;

  logic start_ok, hit, take, last;

  assign start_ok = start && !busy_q;
  assign hit      = !chk_byte[CHK_BIT];
  assign take     = busy_q && hit && !wfound_q;
  assign last     = (idx_q == SW'(SLOTS - 1));
  assign commit   = busy_q && last;

  always_comb begin
    busy_d   = busy_q;
    idx_d    = idx_q;
    wmask_d  = wmask_q;
    wfound_d = wfound_q;
    wfirst_d = wfirst_q;
    wev_d    = wev_q;
    w6_d     = w6_q;
    w7_d     = w7_q;
    done_d   = 1'b0;
    nonslot_d = 1'b0;
    if (start_ok) begin
      busy_d   = 1'b1;
      idx_d    = '0;
      wmask_d  = '0;
      wfound_d = 1'b0;
      wfirst_d = '0;
      wev_d    = 1'b0;
      w6_d     = '0;
      w7_d     = '0;
    end else if (busy_q) begin
      wmask_d[idx_q] = hit;
      if (take) begin
        wfound_d = 1'b1;
        wfirst_d = {1'b0, idx_q} + NW'(1);
        wev_d    = !chk_byte[STAT_BIT];
        w6_d     = chk_byte[STAT_BIT] ? '0 : ext_a;
        w7_d     = chk_byte[STAT_BIT] ? '0 : ext_b;
      end
      idx_d = idx_q + SW'(1);
      if (last) begin
        busy_d    = 1'b0;
        done_d    = 1'b1;
        nonslot_d = (wmask_d == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      wmask_q  <= '0;
      wfound_q <= 1'b0;
      wfirst_q <= '0;
      wev_q    <= 1'b0;
      w6_q     <= '0;
      w7_q     <= '0;
      done     <= 1'b0;
      nonslot  <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      idx_q    <= idx_d;
      wmask_q  <= wmask_d;
      wfound_q <= wfound_d;
      wfirst_q <= wfirst_d;
      wev_q    <= wev_d;
      w6_q     <= w6_d;
      w7_q     <= w7_d;
      done     <= done_d;
      nonslot  <= nonslot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      first_q <= '0;
      ev_q    <= 1'b0;
      e6_q    <= '0;
      e7_q    <= '0;
    end else if (commit) begin
      mask_q  <= wmask_d;
      first_q <= wfirst_d;
      ev_q    <= wev_d;
      e6_q    <= w6_d;
      e7_q    <= w7_d;
    end
  end

  assign cur_slot   = idx_q;
  assign begin_p    = start_ok;
  assign end_p      = commit;
  assign busy       = busy_q;
  assign mask       = mask_q;
  assign first_slot = first_q;
  assign ev         = ev_q;
  assign e6         = e6_q;
  assign e7         = e7_q;
endmodule

// File: rtl/slot_cfg_scan.sv
module slot_cfg_scan
  import slot_cfg_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int REGS  = 8,
  parameter int DW    = 8,
  localparam int SW   = $clog2(SLOTS),
  localparam int RW   = $clog2(REGS),
  localparam int AW   = SW + 1,
  localparam int NW   = SW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [RW-1:0]    host_reg,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             scan_start,
  output logic             scan_busy,
  output logic             scan_done,
  output logic [SLOTS-1:0] chk_mask,
  output logic [NW-1:0]    chk_first_slot,
  output logic             ext_valid,
  output logic [DW-1:0]    ext_pos6,
  output logic [DW-1:0]    ext_pos7,
  output logic             nonslot_err
);
  host_sel_e     sel;
  logic [DW-1:0] board_q;
  logic [AW-1:0] slot_q;
  logic          wr_ok, win_open, begin_p, end_p;
  logic [SW-1:0] scan_slot;
  logic [DW-1:0] bank_rdata, s_chk, s_ext_a, s_ext_b;

  assign sel      = host_sel_e'(host_sel);
  assign wr_ok    = host_wr && !scan_busy;
  assign win_open = slot_q[AW-1] && (board_q == '1);

  slot_cfg_setup #(.DW(DW), .AW(AW)) setup_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_board   (wr_ok && sel == SEL_BOARD),
    .wr_slot    (wr_ok && sel == SEL_SLOT),
    .wdata      (host_wdata),
    .force_off  (begin_p),
    .clear_slot (end_p),
    .board_q    (board_q),
    .slot_q     (slot_q)
  );

  slot_cfg_bank #(.SLOTS(SLOTS), .REGS(REGS), .DW(DW)) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_ok && sel == SEL_WIN && win_open),
    .wslot   (slot_q[SW-1:0]),
    .wreg    (host_reg),
    .wdata   (host_wdata),
    .rslot   (slot_q[SW-1:0]),
    .rreg    (host_reg),
    .rdata   (bank_rdata),
    .sslot   (scan_slot),
    .s_chk   (s_chk),
    .s_ext_a (s_ext_a),
    .s_ext_b (s_ext_b)
  );

  slot_cfg_scanner #(.SLOTS(SLOTS), .DW(DW)) scan_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (scan_start),
    .chk_byte   (s_chk),
    .ext_a      (s_ext_a),
    .ext_b      (s_ext_b),
    .cur_slot   (scan_slot),
    .begin_p    (begin_p),
    .end_p      (end_p),
    .busy       (scan_busy),
    .done       (scan_done),
    .mask       (chk_mask),
    .first_slot (chk_first_slot),
    .ev         (ext_valid),
    .e6         (ext_pos6),
    .e7         (ext_pos7),
    .nonslot    (nonslot_err)
  );

  always_comb begin
    unique case (sel)
      SEL_BOARD: host_rdata = board_q;
      SEL_SLOT:  host_rdata = DW'(slot_q);
      SEL_WIN:   host_rdata = win_open ? bank_rdata : '1;
      default:   host_rdata = '1;
    endcase
  end
endmodule

// File: rtl/slot_cfg_scan_chk.sv
module slot_cfg_scan_chk #(
  parameter int SLOTS = 8,
  parameter int DW    = 8,
  localparam int NW   = $clog2(SLOTS) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       host_sel,
  input logic [DW-1:0]    host_rdata,
  input logic             scan_busy,
  input logic             scan_done,
  input logic [SLOTS-1:0] chk_mask,
  input logic [NW-1:0]    chk_first_slot,
  input logic             ext_valid,
  input logic [DW-1:0]    ext_pos6,
  input logic [DW-1:0]    ext_pos7,
  input logic             nonslot_err
);
  logic [NW-1:0] low_num;

  always_comb begin
    low_num = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (chk_mask[i]) low_num = NW'(i + 1);
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_busy) |-> scan_done);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |-> $stable(chk_mask));

  p_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> chk_first_slot == low_num);

  p_ext_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !ext_valid) |-> (ext_pos6 == '0 && ext_pos7 == '0));

  p_nonslot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nonslot_err |-> (scan_done && chk_mask == '0));

  p_slot_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && host_sel == 2'd1) |-> host_rdata == '0);
endmodule

bind slot_cfg_scan slot_cfg_scan_chk #(.SLOTS(SLOTS), .DW(DW)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_sel       (host_sel),
  .host_rdata     (host_rdata),
  .scan_busy      (scan_busy),
  .scan_done      (scan_done),
  .chk_mask       (chk_mask),
  .chk_first_slot (chk_first_slot),
  .ext_valid      (ext_valid),
  .ext_pos6       (ext_pos6),
  .ext_pos7       (ext_pos7),
  .nonslot_err    (nonslot_err)
);

// File: tb/slot_cfg_scan_tb_top.sv
module slot_cfg_scan_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_sel = 2'd3;
  logic [2:0] host_reg = '0;
  logic [7:0] host_wdata = '0;
  logic       scan_start = 1'b0;
  logic [7:0] host_rdata, chk_mask, ext_pos6, ext_pos7;
  logic [3:0] chk_first_slot;
  logic       scan_busy, scan_done, ext_valid, nonslot_err;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [8][8];

  always #10 clk = ~clk;

  slot_cfg_scan dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .scan_start(scan_start), .scan_busy(scan_busy), .scan_done(scan_done),
    .chk_mask(chk_mask), .chk_first_slot(chk_first_slot), .ext_valid(ext_valid),
    .ext_pos6(ext_pos6), .ext_pos7(ext_pos7), .nonslot_err(nonslot_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_reg = r; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] sel, input logic [2:0] r, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_reg = r;
    #1 d = host_rdata;
  endtask

  task automatic win_write(input int s, input int r, input logic [7:0] d);
    hwrite(2'd0, 3'd0, 8'hFF);
    hwrite(2'd1, 3'd0, 8'h08 | 8'(s));
    hwrite(2'd2, 3'(r), d);
    hwrite(2'd1, 3'd0, 8'h00);
    model[s][r] = d;
  endtask

  function automatic logic [7:0] exp_mask();
    logic [7:0] m = '0;
    for (int s = 0; s < 8; s++) m[s] = ~model[s][5][7];
    return m;
  endfunction

  function automatic logic [3:0] exp_first();
    for (int s = 0; s < 8; s++) if (!model[s][5][7]) return 4'(s + 1);
    return 4'd0;
  endfunction

  task automatic run_scan(input bit disturb);
    int cnt;
    logic [7:0] rd, m;
    logic [3:0] f;
    bit ev;
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    cnt = 1;
    check(scan_busy === 1'b1, "R6 busy after start", 32'(scan_busy), 1);
    while (scan_done !== 1'b1 && cnt < 40) begin
      @(negedge clk);
      cnt++;
      scan_start = disturb && (cnt == 3);
      host_wr = disturb && (cnt == 5);
      host_sel = 2'd1; host_wdata = 8'h0D;
    end
    scan_start = 1'b0; host_wr = 1'b0;
    check(cnt == 9, "R6 done timing", 32'(cnt), 9);
    check(scan_busy === 1'b0, "R6 busy low at done", 32'(scan_busy), 0);
    m = exp_mask(); f = exp_first();
    ev = (f != 0) && !model[f-1][5][6];
    check(chk_mask === m, "R7 mask", 32'(chk_mask), 32'(m));
    check(chk_first_slot === f, "R8 first slot", 32'(chk_first_slot), 32'(f));
    check(ext_valid === ev, "R8 ext valid", 32'(ext_valid), 32'(ev));
    check(ext_pos6 === (ev ? model[f-1][6] : 8'h00), "R8 ext6", 32'(ext_pos6),
          32'(ev ? model[f-1][6] : 8'h00));
    check(ext_pos7 === (ev ? model[f-1][7] : 8'h00), "R8 ext7", 32'(ext_pos7),
          32'(ev ? model[f-1][7] : 8'h00));
    check(nonslot_err === (m == 0), "R9 nonslot", 32'(nonslot_err), 32'(m == 0));
    @(negedge clk);
    check(scan_done === 1'b0, "R6 done one cycle", 32'(scan_done), 0);
    hread(2'd1, 3'd0, rd);
    check(rd === 8'h00, "R10 slot select cleared", 32'(rd), 0);
    hread(2'd0, 3'd0, rd);
    check(rd === 8'hFF, "R10 board setup off", 32'(rd), 32'hFF);
    if (disturb) begin
      bit seen = 0;
      repeat (12) begin
        @(negedge clk);
        if (scan_done) seen = 1;
      end
      check(!seen, "R11 second start ignored", 32'(seen), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4242));
    for (int s = 0; s < 8; s++) for (int r = 0; r < 8; r++) model[s][r] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    hread(2'd0, 3'd0, rd); check(rd === 8'hFF, "R1 board reset", 32'(rd), 32'hFF);
    hread(2'd1, 3'd0, rd); check(rd === 8'h00, "R1 slot select reset", 32'(rd), 0);
    check({scan_busy, scan_done, nonslot_err, ext_valid} === 4'b0, "R1 flags",
          32'({scan_busy, scan_done, nonslot_err, ext_valid}), 0);
    check({chk_mask, chk_first_slot, ext_pos6, ext_pos7} === '0, "R1 results",
          32'(chk_mask), 0);
    hwrite(2'd1, 3'd0, 8'h0B);
    hread(2'd2, 3'd4, rd); check(rd === 8'hFF, "R1 bank reset", 32'(rd), 32'hFF);

    // R2
    hwrite(2'd1, 3'd0, 8'hF5);
    hread(2'd1, 3'd0, rd); check(rd === 8'h05, "R2 upper bits dropped", 32'(rd), 5);
    hread(2'd3, 3'd0, rd); check(rd === 8'hFF, "R2 unmapped read", 32'(rd), 32'hFF);

    // R3
    win_write(2, 1, 8'h3C);
    win_write(5, 1, 8'hA7);
    hwrite(2'd1, 3'd0, 8'h0A);
    hread(2'd2, 3'd1, rd); check(rd === 8'h3C, "R3 slot 2 readback", 32'(rd), 32'h3C);
    hwrite(2'd1, 3'd0, 8'h0D);
    hread(2'd2, 3'd1, rd); check(rd === 8'hA7, "R3 slot 5 readback", 32'(rd), 32'hA7);

    // R4
    hwrite(2'd1, 3'd0, 8'h02);
    hread(2'd2, 3'd1, rd); check(rd === 8'hFF, "R4 closed read", 32'(rd), 32'hFF);
    hwrite(2'd2, 3'd1, 8'h11);
    hwrite(2'd1, 3'd0, 8'h0A);
    hread(2'd2, 3'd1, rd); check(rd === 8'h3C, "R4 closed write ignored", 32'(rd), 32'h3C);

    // R5
    hwrite(2'd0, 3'd0, 8'h7F);
    hread(2'd2, 3'd1, rd); check(rd === 8'hFF, "R5 board setup blocks read", 32'(rd), 32'hFF);
    hwrite(2'd2, 3'd1, 8'h22);
    hwrite(2'd0, 3'd0, 8'hFF);
    hread(2'd2, 3'd1, rd); check(rd === 8'h3C, "R5 blocked write ignored", 32'(rd), 32'h3C);

    // R9: nothing checking; R10 with board setup active before the scan
    hwrite(2'd0, 3'd0, 8'h00);
    run_scan(1'b0);

    // R7 R8: only the last slot checking, extended status present
    win_write(7, 5, 8'h3F); win_write(7, 6, 8'h5A); win_write(7, 7, 8'hC3);
    run_scan(1'b0);

    // slots 0 and 3 checking, slot 0 without extended status; R11 disturbance
    win_write(0, 5, 8'h7F); win_write(3, 5, 8'h3F); win_write(0, 6, 8'h12);
    run_scan(1'b1);

    // random rounds
    for (int k = 0; k < 12; k++) begin
      for (int s = 0; s < 8; s++) begin
        logic [7:0] v = 8'($urandom);
        if (($urandom % 4) != 0) v[7] = 1'b1;
        win_write(s, 5, v);
        win_write(s, 6, 8'($urandom));
        win_write(s, 7, 8'($urandom));
      end
      run_scan(k[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule